// File: doc/BRIEF.md
# Dual-Tone Keypad Signal Generator

This block turns a 4-bit key code into a stream of signed digital samples that carry the two tones of a telephone keypad signal. One tone comes from a row group (697, 770, 852 or 941 Hz) and the other from a column group (1209, 1336, 1477 or 1633 Hz). Each group has its own integer divider. The divider derives a sample strobe from the reference clock. The strobe advances a phase counter that indexes a full-period sine table. The two table outputs are added and registered as one 9-bit sample word, which is intended for a downstream converter.

The block has two modes. In continuous mode the pair plays for as long as `tx_en` is high. In timed mode a code write starts one tone burst, followed by a silent pause of equal length. After the pause the block raises `ready` again. An extended setting doubles both the burst and the pause. With the default 3.579545 MHz reference, the parameter values give 100 ms and 200 ms.

Top module: `dtmf_burst_gen`

## Requirements
- R1: While reset is asserted, and after its release with no activity, `tone_out` is 0 and `ready` is 1.
- R2: Key code mapping, given as (row Hz, column Hz): codes 1..9 map to keys 1..9 in reading order on a 3x3 grid, so row = (c-1)/3 and column = (c-1)%3. Code 10 is (941,1336), 11 is (941,1209) and 12 is (941,1477). Codes 13, 14 and 15 are (697,1633), (770,1633) and (852,1633). Code 0 is (941,1633).
- R3: For each tone of f Hz, the divider is D = floor((REF_HZ + 16f) / (32f)), which is REF_HZ/(32f) rounded to the nearest integer. The phase advances once every D clock cycles.
- R4: Sine table entry k (k = 0..31) is 127·sin(2πk/32) rounded to the nearest integer. Every tone start begins at phase 0 with a cleared divider, and the phase wraps from 31 to 0.
- R5: Let the sequencers start counting in the cycle after edge E0. Sampled after edge Ej (j ≥ 1), `tone_out` equals S(((j-1)/DL) mod 32) + S(((j-1)/DH) mod 32) as a 9-bit signed value, where S is the table and DL and DH are the two dividers. After E0 itself the output is 0.
- R6: In continuous mode (`burst_en`=0), the output follows `tx_en`: a rise sampled at E0 starts the pair as in R5. A fall sampled at edge F0 makes `tone_out` 0 from edge F1 on.
- R7: In timed mode (`burst_en`=1), a `code_wr` at edge E0 while `ready` is high starts a burst of BURST_CYC clock cycles (samples after E1..E_BURST_CYC follow R5). `tone_out` is then 0 through a pause of BURST_CYC cycles. `ready` is 0 from E0 until edge E(2·BURST_CYC), after which it is 1. `tx_en` has no effect in this mode.
- R8: If `ext_burst` is 1 at the starting write, the burst and the pause each last 2·BURST_CYC cycles.
- R9: In timed mode, a `code_wr` while `ready` is 0 is ignored: the burst in progress keeps its tone pair and timing.
- R10: In continuous mode, `ready` stays 1 and each `code_wr` loads a new code. The new code is the one played at the next start.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| burst_en | input | 1 | 1 selects timed burst mode, 0 selects continuous mode |
| ext_burst | input | 1 | Doubles burst and pause length, captured at burst start |
| tx_en | input | 1 | Continuous-mode tone enable |
| code_wr | input | 1 | Write strobe for `code` |
| code | input | 4 | Key code |
| ready | output | 1 | High when a new code may start a burst |
| tone_out | output | SMP_W+1 | Signed sum of the row and column samples |

## Verification
The bench checks every one of the 16 codes cycle by cycle against an arithmetic model. A wrong divider rounding or a swapped key-map entry therefore shows up as a sample mismatch within a few phase steps. A long run on the 697/1633 pair crosses the 31-to-0 phase wrap, which catches a phase counter that saturates or skips. The bench times timed bursts, both normal and extended, to the exact cycle at each end of the tone and the pause. A timer off by one therefore leaks a sample into the pause or raises `ready` early. During one burst the bench injects writes in both the tone and the pause phases. A design that accepted them would switch tones mid-burst or restart the timer.

// File: rtl/dtmf_pkg.sv
package dtmf_pkg;

  localparam int unsigned ROW_HZ [4] = '{697, 770, 852, 941};
  localparam int unsigned COL_HZ [4] = '{1209, 1336, 1477, 1633};

  typedef enum logic [1:0] {
    TM_IDLE  = 2'd0,
    TM_TONE  = 2'd1,
    TM_PAUSE = 2'd2
  } tmr_state_e;

  // nearest-integer clock divider for one sample step of a tone
  function automatic int unsigned tone_div(int unsigned ref_hz, int unsigned hz,
                                           int unsigned steps);
    return (ref_hz + (hz * steps) / 2) / (hz * steps);
  endfunction

  // rounded sine sample, computed at elaboration
  function automatic int sine_code(int k, int steps, int amp);
    real x;
    x = real'(amp) * $sin(2.0 * 3.14159265358979 * real'(k) / real'(steps));
    if (x >= 0.0) return $rtoi(x + 0.5);
    else          return -$rtoi(-x + 0.5);
  endfunction

endpackage

// File: rtl/dtmf_keymap.sv
module dtmf_keymap (
  input  logic [3:0] code,
  output logic [1:0] row_idx,
  output logic [1:0] col_idx
);
  always_comb begin
    unique case (code)
      4'd1:  begin row_idx = 2'd0; col_idx = 2'd0; end
      4'd2:  begin row_idx = 2'd0; col_idx = 2'd1; end
      4'd3:  begin row_idx = 2'd0; col_idx = 2'd2; end
      4'd4:  begin row_idx = 2'd1; col_idx = 2'd0; end
      4'd5:  begin row_idx = 2'd1; col_idx = 2'd1; end
      4'd6:  begin row_idx = 2'd1; col_idx = 2'd2; end
      4'd7:  begin row_idx = 2'd2; col_idx = 2'd0; end
      4'd8:  begin row_idx = 2'd2; col_idx = 2'd1; end
      4'd9:  begin row_idx = 2'd2; col_idx = 2'd2; end
      4'd10: begin row_idx = 2'd3; col_idx = 2'd1; end
      4'd11: begin row_idx = 2'd3; col_idx = 2'd0; end
      4'd12: begin row_idx = 2'd3; col_idx = 2'd2; end
      4'd13: begin row_idx = 2'd0; col_idx = 2'd3; end
      4'd14: begin row_idx = 2'd1; col_idx = 2'd3; end
      4'd15: begin row_idx = 2'd2; col_idx = 2'd3; end
      default: begin row_idx = 2'd3; col_idx = 2'd3; end
    endcase
  end
endmodule

// File: rtl/dtmf_tone_seq.sv
module dtmf_tone_seq #(
  parameter int unsigned DIV_W = 16,
  parameter int unsigned STEPS = 32,
  parameter int unsigned SMP_W = 8
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    run,
  input  logic [DIV_W-1:0]        div,
  output logic signed [SMP_W-1:0] sample
);
  import dtmf_pkg::*;

  localparam int unsigned PH_W = $clog2(STEPS);
  localparam int          AMP  = (1 << (SMP_W - 1)) - 1;

  logic signed [SMP_W-1:0] tbl [STEPS];
  for (genvar k = 0; k < STEPS; k++) begin : g_tbl
    assign tbl[k] = SMP_W'(sine_code(k, STEPS, AMP));
  end

  logic [DIV_W-1:0] cnt_q, cnt_d;
  logic [PH_W-1:0]  phase_q, phase_d;
  logic             step;

  always_comb begin
    step    = (cnt_q >= div - DIV_W'(1));
    cnt_d   = cnt_q;
    phase_d = phase_q;
    if (!run) begin
      cnt_d   = '0;
      phase_d = '0;
    end else if (step) begin
      cnt_d   = '0;
      phase_d = phase_q + PH_W'(1);
    end else begin
      cnt_d   = cnt_q + DIV_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      phase_q <= '0;
    end else begin
      cnt_q   <= cnt_d;
      phase_q <= phase_d;
    end
  end

  assign sample = tbl[phase_q];

  AST_DIV_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> div != '0); // R3
  AST_PHASE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (run && $past(run) && phase_q != $past(phase_q)) |-> phase_q == $past(phase_q) + PH_W'(1)); // R4
  AST_IDLE_PHASE0: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(run) |-> phase_q == '0); // R4

endmodule

// File: rtl/dtmf_burst_timer.sv
module dtmf_burst_timer #(
  parameter int unsigned BURST_CYC = 357955
) (
  input  logic clk,
  input  logic rst_n,
  input  logic burst_en,
  input  logic ext_burst,
  input  logic tx_en,
  input  logic start,
  output logic gate,
  output logic ready
);
  import dtmf_pkg::*;

  localparam int unsigned CNT_W = $clog2(2 * BURST_CYC);
  localparam logic [CNT_W-1:0] LAST_N = CNT_W'(BURST_CYC - 1);
  localparam logic [CNT_W-1:0] LAST_X = CNT_W'(2 * BURST_CYC - 1);

  tmr_state_e       state_q, state_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             ext_q, ext_d;
  logic             gate_q, gate_d;
  logic             at_end;

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    ext_d   = ext_q;
    at_end  = (cnt_q == (ext_q ? LAST_X : LAST_N));
    unique case (state_q)
      TM_IDLE: if (burst_en && start) begin
        state_d = TM_TONE;
        cnt_d   = '0;
        ext_d   = ext_burst;
      end
      TM_TONE: if (at_end) begin
        state_d = TM_PAUSE;
        cnt_d   = '0;
      end else begin
        cnt_d   = cnt_q + CNT_W'(1);
      end
      TM_PAUSE: if (at_end) begin
        state_d = TM_IDLE;
        cnt_d   = '0;
      end else begin
        cnt_d   = cnt_q + CNT_W'(1);
      end
      default: state_d = TM_IDLE;
    endcase
    if (!burst_en) begin
      state_d = TM_IDLE;
      cnt_d   = '0;
    end
    gate_d = burst_en ? (state_d == TM_TONE) : tx_en;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= TM_IDLE;
      cnt_q   <= '0;
      ext_q   <= 1'b0;
      gate_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      ext_q   <= ext_d;
      gate_q  <= gate_d;
    end
  end

  assign gate  = gate_q;
  assign ready = (state_q == TM_IDLE);

  AST_TONE_LEN: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == TM_PAUSE && $past(state_q) == TM_TONE) |-> $past(cnt_q) == (ext_q ? LAST_X : LAST_N)); // R8
  AST_READY_AFTER_PAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(ready) && $past(burst_en)) |-> $past(state_q) == TM_PAUSE); // R7
  AST_PAUSE_GATE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == TM_PAUSE) |-> !gate_q); // R7

endmodule

// File: rtl/dtmf_burst_gen.sv
module dtmf_burst_gen #(
  parameter int unsigned REF_HZ    = 3579545,
  parameter int unsigned STEPS     = 32,
  parameter int unsigned SMP_W     = 8,
  parameter int unsigned DIV_W     = 16,
  parameter int unsigned BURST_CYC = 357955
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  burst_en,
  input  logic                  ext_burst,
  input  logic                  tx_en,
  input  logic                  code_wr,
  input  logic [3:0]            code,
  output logic                  ready,
  output logic signed [SMP_W:0] tone_out
);
  import dtmf_pkg::*;

  // reset: asynchronous assert, synchronous release
  logic [1:0] rst_sync_q;
  logic       rst_i_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= '0;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_i_n = rst_sync_q[1];

  // code register
  logic [3:0] code_q, code_d;
  always_comb code_d = (code_wr && ready) ? code : code_q;
  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) code_q <= '0;
    else          code_q <= code_d;
  end

  logic [1:0] sel [2];
  dtmf_keymap u_map (.code(code_q), .row_idx(sel[0]), .col_idx(sel[1]));

  logic gate;
  dtmf_burst_timer #(.BURST_CYC(BURST_CYC)) u_tmr (
    .clk(clk), .rst_n(rst_i_n), .burst_en(burst_en), .ext_burst(ext_burst),
    .tx_en(tx_en), .start(code_wr), .gate(gate), .ready(ready)
  );

  // divider constants per group and tone
  logic [DIV_W-1:0]        div_tbl [2][4];
  logic signed [SMP_W-1:0] smp [2];
  for (genvar g = 0; g < 2; g++) begin : g_grp
    for (genvar t = 0; t < 4; t++) begin : g_tone
      assign div_tbl[g][t] = DIV_W'(tone_div(REF_HZ, (g == 0) ? ROW_HZ[t] : COL_HZ[t], STEPS));
    end
    dtmf_tone_seq #(.DIV_W(DIV_W), .STEPS(STEPS), .SMP_W(SMP_W)) u_seq (
      .clk(clk), .rst_n(rst_i_n), .run(gate), .div(div_tbl[g][sel[g]]), .sample(smp[g])
    );
  end

  // output sum: two SMP_W samples of magnitude <= 2^(SMP_W-1)-1 fit SMP_W+1 bits
  logic signed [SMP_W:0] sum_d, sum_q;
  always_comb begin
    sum_d = '0;
    if (gate) sum_d = {smp[0][SMP_W-1], smp[0]} + {smp[1][SMP_W-1], smp[1]};
  end
  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) sum_q <= '0;
    else          sum_q <= sum_d;
  end
  assign tone_out = sum_q;

  AST_BUSY_WRITE_IGNORED: assert property (@(posedge clk) disable iff (!rst_i_n)
    (code_wr && !ready) |=> $stable(code_q)); // R9
  AST_SILENT_AFTER_GATE: assert property (@(posedge clk) disable iff (!rst_i_n)
    !$past(gate) |-> tone_out == '0); // R6
  AST_CONT_READY: assert property (@(posedge clk) disable iff (!rst_i_n)
    (!burst_en && !$past(burst_en)) |-> ready); // R10
  AST_SUM_RANGE: assert property (@(posedge clk) disable iff (!rst_i_n)
    (tone_out <= (SMP_W+1)'(2 * ((1 << (SMP_W - 1)) - 1))) && (tone_out >= -(SMP_W+1)'(2 * ((1 << (SMP_W - 1)) - 1)))); // R5

endmodule

// File: tb/sim_dtmf_burst_gen.sv
module sim_dtmf_burst_gen;
  localparam int REF = 3579545;
  localparam int N   = 32;
  localparam int BC  = 600;

  logic clk = 1'b0;
  logic rst_n, burst_en, ext_burst, tx_en, code_wr;
  logic [3:0] code;
  logic ready;
  logic signed [8:0] tone_out;
  int nchk = 0, nfail = 0;
  bit done = 0;

  always #2 clk = ~clk;

  dtmf_burst_gen #(.REF_HZ(REF), .STEPS(N), .SMP_W(8), .DIV_W(16), .BURST_CYC(BC)) u0 (
    .clk(clk), .rst_n(rst_n), .burst_en(burst_en), .ext_burst(ext_burst), .tx_en(tx_en),
    .code_wr(code_wr), .code(code), .ready(ready), .tone_out(tone_out));

  function automatic int sref(int k);
    real x;
    x = 127.0 * $sin(2.0 * 3.14159265358979 * real'(k) / 32.0);
    return (x >= 0.0) ? $rtoi(x + 0.5) : -$rtoi(-x + 0.5);
  endfunction

  function automatic int row_hz(int c);
    int r;
    if (c >= 1 && c <= 9) r = (c - 1) / 3;
    else if (c >= 13) r = c - 13;
    else r = 3;
    case (r) 0: return 697; 1: return 770; 2: return 852; default: return 941; endcase
  endfunction

  function automatic int col_hz(int c);
    int k;
    if (c >= 1 && c <= 9) k = (c - 1) % 3;
    else if (c == 10) k = 1;
    else if (c == 11) k = 0;
    else if (c == 12) k = 2;
    else k = 3;
    case (k) 0: return 1209; 1: return 1336; 2: return 1477; default: return 1633; endcase
  endfunction

  function automatic int dv(int hz);
    return (REF + 16 * hz) / (32 * hz);
  endfunction

  function automatic int model(int c, int j);
    if (j < 1) return 0;
    return sref(((j - 1) / dv(row_hz(c))) % N) + sref(((j - 1) / dv(col_hz(c))) % N);
  endfunction

  task automatic chk(bit ok, string req, int act, int exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // continuous mode: load code while silent, play n cycles, then stop
  task automatic cont_play(int c, int n);
    int bad = 0, fa = 0, fe = 0;
    burst_en = 1'b0;
    @(negedge clk); code = 4'(c); code_wr = 1'b1;
    @(negedge clk); code_wr = 1'b0; tx_en = 1'b1;
    for (int j = 0; j <= n; j++) begin
      @(negedge clk);
      if (32'(tone_out) != model(c, j) && bad == 0) begin fa = int'(tone_out); fe = model(c, j); end
      if (int'(tone_out) != model(c, j)) bad++;
    end
    chk(bad == 0, "R2/R3/R4/R5 waveform", fa, fe);
    chk(ready == 1'b1, "R10 ready in continuous mode", int'(ready), 1);
    tx_en = 1'b0;
    @(negedge clk);
    @(negedge clk);
    chk(tone_out == 0, "R6 silent after disable", int'(tone_out), 0);
  endtask

  // timed mode burst, optional intruding writes
  task automatic burst_play(int c, bit ext, bit intrude);
    int len = ext ? 2 * BC : BC;
    int tb = 0, ta = 0, te = 0, pb = 0, pa = 0, rb = 0, ra = 0, re = 0;
    burst_en = 1'b1; ext_burst = ext; tx_en = 1'b0;
    @(negedge clk); code = 4'(c); code_wr = 1'b1;
    @(negedge clk); code_wr = 1'b0;
    chk(ready == 1'b0, "R7 ready drops at start", int'(ready), 0);
    for (int j = 1; j <= 2 * len; j++) begin
      if (intrude && (j == len / 2 || j == len + 5)) begin
        code = 4'((c + 5) % 16); code_wr = 1'b1; ext_burst = ~ext;
      end else begin
        code_wr = 1'b0;
      end
      @(negedge clk);
      if (j <= len) begin
        if (int'(tone_out) != model(c, j)) begin
          if (tb == 0) begin ta = int'(tone_out); te = model(c, j); end
          tb++;
        end
      end else if (tone_out != 0) begin
        if (pb == 0) pa = int'(tone_out);
        pb++;
      end
      if (ready != (j == 2 * len)) begin
        if (rb == 0) begin ra = int'(ready); re = (j == 2 * len) ? 1 : 0; end
        rb++;
      end
    end
    code_wr = 1'b0; ext_burst = 1'b0;
    chk(tb == 0, intrude ? "R9 burst tone kept" : (ext ? "R8 extended tone" : "R7 burst tone"), ta, te);
    chk(pb == 0, ext ? "R8 extended pause silent" : "R7 pause silent", pa, 0);
    chk(rb == 0, ext ? "R8 ready timing" : "R7 ready timing", ra, re);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nfail++; nchk++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("[TB] %0d tests run, %0d failed", nchk, nfail);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; burst_en = 1'b0; ext_burst = 1'b0; tx_en = 1'b0; code_wr = 1'b0; code = '0;
    repeat (3) @(negedge clk);
    chk(tone_out == 0, "R1 output in reset", int'(tone_out), 0);
    chk(ready == 1'b1, "R1 ready in reset", int'(ready), 1);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(tone_out == 0 && ready == 1'b1, "R1 after release", int'(tone_out), 0);

    for (int c = 0; c < 16; c++) cont_play(c, 1200);
    cont_play(13, 5200);  // crosses phase wrap of both tones (R4)

    burst_play(5, 1'b0, 1'b0);
    burst_play(11, 1'b0, 1'b1);
    burst_play(12, 1'b1, 1'b0);
    burst_play(0, 1'b1, 1'b1);

    // R7: tx_en high in timed mode with no write gives no tone
    burst_en = 1'b1; tx_en = 1'b1;
    repeat (50) @(negedge clk);
    chk(tone_out == 0, "R7 tx_en ignored in timed mode", int'(tone_out), 0);
    tx_en = 1'b0;

    done = 1;
    $display("[TB] %0d tests run, %0d failed", nchk, nfail);
    $finish;
  end
endmodule